// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block decides which of eight interrupt sources a small 8-bit processor core services next. The eight sources are:

- four active-low external pins,
- two timer overflow pulses,
- a serial-port request,
- a third timer's request.

Each source has an enable and a priority level. The four external pins can each be set to falling-edge or low-level triggering. Requests are held in flag bits. The block picks the winner by priority level first and then by a fixed polling order. It presents that winner to the core as a request line with an 8-bit vector address.

The core acknowledges the request. The acknowledge records which level is now in service and clears any edge-type flag that belongs to the winner. The core later signals the return from interrupt, which ends the service at the current level.

All control state lives in four special-function registers. Each one can be written as a whole byte or one bit at a time by bit address. Software writes to flag bits act like hardware events, so software can raise or withdraw a request.

Top module: `irq_arbiter8`

## Requirements
- R1: After reset the irq output is 0, and all four registers read 0. The registers are: control at 88h, enable at A8h, level at B8h, and extension at C0h. Bits that are not implemented read 0: control bits 4 and 6, enable bit 6, and level bits 6 and 7.
- R2: A bit write addresses bit n of the register at base b as bit address b+n. For example, bit address C2h sets extension bit 2 (the enable for source 6). A byte write on sfr_wr replaces the whole register.
- R3: In edge mode, a falling edge on a pin sets that pin's flag. The request becomes visible on irq on the third rising clock edge after the pin falls. A pin that stays low does not set the flag again.
- R4: In level mode, the flag follows the inverted pin with the same three-edge delay, and acknowledge does not clear it. Control bit 0 is the mode for pin 0 and bit 2 for pin 1; extension bit 0 is the mode for pin 2 and bit 4 for pin 3. A value of 1 selects edge, 0 selects level.
- R5: A source can request only when its own enable bit and enable bit 7 (the global enable) are both 1. Enable bits 0 to 5 belong to sources 0 to 5. Extension bit 2 belongs to source 6 and extension bit 6 to source 7.
- R6: Source indices follow the polling order: 0 pin 0, 1 timer 0, 2 pin 1, 3 timer 1, 4 serial, 5 third timer, 6 pin 2, 7 pin 3. While irq is 1, irq_vec equals 8 times the winner's index plus 3.
- R7: Any enabled pending source at the high level beats every source at the low level. Within one level, the lower index wins. Level bits 0 to 5 belong to sources 0 to 5, extension bit 3 to source 6 and extension bit 7 to source 7.
- R8: An acknowledge while irq is 1 clears the winner's flag if that flag is edge-type: an edge-mode pin flag, timer 0 flag (control bit 5) or timer 1 flag (control bit 7). Level flags, the serial request and the third-timer request are left as they are. An acknowledge while irq is 0 has no effect.
- R9: While a low-level service is open, only high-level sources raise irq. While a high-level service is open, irq stays 0. Each return closes the innermost open level.
- R10: A software write to a flag bit raises or withdraws that request in the cycle after the write.
- R11: A pulse on tmr0_ovf or tmr1_ovf sets the matching timer flag at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n | input | 4 | External interrupt pins 0 to 3, active low, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_req | input | 1 | Third timer request, level |
| ser_req | input | 1 | Serial port request, level |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_waddr | input | 8 | Byte write address |
| sfr_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit address (register base plus bit number) |
| bit_val | input | 1 | Bit write value |
| sfr_raddr | input | 8 | Read address |
| sfr_rdata | output | 8 | Read data, combinational |
| cpu_ack | input | 1 | Interrupt acknowledge from the core |
| cpu_reti | input | 1 | Return-from-interrupt from the core |
| irq | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the current winner |

## Verification
A wrong flag bit shows up on the ports in one of two ways. It appears as a wrong winner on irq_vec at the very next sample, or as a wrong bit on sfr_rdata when the register is read back.

A corrupted service-level state shows up differently: requests that should be blocked appear, or requests that should appear stay hidden. This becomes visible only once a second request arrives during a service. For that reason the nesting and return sequences are driven step by step.

Errors in the pin synchronizer or the edge detector shift the cycle in which irq rises away from the third edge after the pin falls. They can also make the request fire again while the pin is still held low.

// File: rtl/irq_arbiter8.sv
module irq_arbiter8 #(
  parameter logic [7:0] A_CTL = 8'h88,
  parameter logic [7:0] A_EN  = 8'hA8,
  parameter logic [7:0] A_LVL = 8'hB8,
  parameter logic [7:0] A_EXT = 8'hC0,
  parameter int         NSRC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ext_n,
  input  logic       tmr0_ovf,
  input  logic       tmr1_ovf,
  input  logic       tmr2_req,
  input  logic       ser_req,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_waddr,
  input  logic [7:0] sfr_wdata,
  input  logic       bit_wr,
  input  logic [7:0] bit_addr,
  input  logic       bit_val,
  input  logic [7:0] sfr_raddr,
  output logic [7:0] sfr_rdata,
  input  logic       cpu_ack,
  input  logic       cpu_reti,
  output logic       irq,
  output logic [7:0] irq_vec
);
  localparam int IW = $clog2(NSRC);
  localparam logic [7:0] M_CTL = 8'hAF;
  localparam logic [7:0] M_EN  = 8'hBF;
  localparam logic [7:0] M_LVL = 8'h3F;

  logic [7:0] ctl_q, en_q, lvl_q, ext_q;
  logic [7:0] ctl_n, en_n, lvl_n, ext_n_reg;
  logic [3:0] s1, s2, prv, fall;
  logic       in_hi, in_lo;
  logic [NSRC-1:0] pend, ena, lvl, act, hi, pool, clr;
  logic [IW-1:0]   win;
  logic            win_hi, take;

  function automatic logic [7:0] put(input logic [7:0] v, input logic [7:0] base,
                                     input logic bw, input logic [7:0] wa, input logic [7:0] wd,
                                     input logic bb, input logic [7:0] ba, input logic bv);
    logic [7:0] r;
    r = v;
    if (bw && wa == base) r = wd;
    else if (bb && ba[7:3] == base[7:3]) r[ba[2:0]] = bv;
    return r;
  endfunction

  wire ctl_touch = (sfr_wr && sfr_waddr == A_CTL) || (bit_wr && bit_addr[7:3] == A_CTL[7:3]);

  assign fall = prv & ~s2;
  assign pend = {ext_q[5], ext_q[1], tmr2_req, ser_req, ctl_q[7], ctl_q[3], ctl_q[5], ctl_q[1]};
  assign ena  = {NSRC{en_q[7]}} & {ext_q[6], ext_q[2], en_q[5:0]};
  assign lvl  = {ext_q[7], ext_q[3], lvl_q[5:0]};
  assign act  = pend & ena;
  assign hi   = act & lvl;
  assign win_hi = |hi;
  assign pool = win_hi ? hi : act;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pool[i]) win = IW'(i);
  end

  assign irq     = !in_hi && (win_hi || (|act && !in_lo));
  assign irq_vec = {win, 3'b011};
  assign take    = cpu_ack && irq;
  assign clr     = take ? (NSRC'(1) << win) : '0;

  always_comb begin
    ctl_n = ctl_q;
    if (clr[0]) ctl_n[1] = 1'b0;
    if (clr[1]) ctl_n[5] = 1'b0;
    if (clr[2]) ctl_n[3] = 1'b0;
    if (clr[3]) ctl_n[7] = 1'b0;
    if (fall[0] && ctl_q[0]) ctl_n[1] = 1'b1;
    if (fall[1] && ctl_q[2]) ctl_n[3] = 1'b1;
    if (tmr0_ovf) ctl_n[5] = 1'b1;
    if (tmr1_ovf) ctl_n[7] = 1'b1;
    ctl_n = put(ctl_n, A_CTL, sfr_wr, sfr_waddr, sfr_wdata, bit_wr, bit_addr, bit_val) & M_CTL;
    if (!ctl_n[0]) ctl_n[1] = !s2[0];
    if (!ctl_n[2]) ctl_n[3] = !s2[1];
  end

  always_comb begin
    ext_n_reg = ext_q;
    if (clr[6]) ext_n_reg[1] = 1'b0;
    if (clr[7]) ext_n_reg[5] = 1'b0;
    if (fall[2] && ext_q[0]) ext_n_reg[1] = 1'b1;
    if (fall[3] && ext_q[4]) ext_n_reg[5] = 1'b1;
    ext_n_reg = put(ext_n_reg, A_EXT, sfr_wr, sfr_waddr, sfr_wdata, bit_wr, bit_addr, bit_val);
    if (!ext_n_reg[0]) ext_n_reg[1] = !s2[2];
    if (!ext_n_reg[4]) ext_n_reg[5] = !s2[3];
  end

  assign en_n  = put(en_q,  A_EN,  sfr_wr, sfr_waddr, sfr_wdata, bit_wr, bit_addr, bit_val) & M_EN;
  assign lvl_n = put(lvl_q, A_LVL, sfr_wr, sfr_waddr, sfr_wdata, bit_wr, bit_addr, bit_val) & M_LVL;

  always_comb begin
    case (sfr_raddr)
      A_CTL:   sfr_rdata = ctl_q;
      A_EN:    sfr_rdata = en_q;
      A_LVL:   sfr_rdata = lvl_q;
      A_EXT:   sfr_rdata = ext_q;
      default: sfr_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; prv <= '1;
      ctl_q <= '0; en_q <= '0; lvl_q <= '0; ext_q <= '0;
      in_hi <= 1'b0; in_lo <= 1'b0;
    end else begin
      s1 <= ext_n; s2 <= s1; prv <= s2;
      ctl_q <= ctl_n; en_q <= en_n; lvl_q <= lvl_n; ext_q <= ext_n_reg;
      if (cpu_reti) begin
        if (in_hi) in_hi <= 1'b0;
        else       in_lo <= 1'b0;
      end
      if (take) begin
        if (win_hi) in_hi <= 1'b1;
        else        in_lo <= 1'b1;
      end
    end
  end

  // R9
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cpu_reti) |=> (in_hi || in_lo));
  // R9
  reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reti && in_hi && !take) |=> !in_hi);
  // R9
  busy_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hi |-> !irq);
  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && fall[0] && !ctl_touch) |=> ctl_q[1]);
  // R8
  tf0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vec == 8'h0B && !tmr0_ovf && !ctl_touch) |=> !ctl_q[5]);
endmodule

// File: tb/irq_arbiter8_tb.sv
module irq_arbiter8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_n = 4'hF;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_req = 1'b0, ser_req = 1'b0;
  logic       sfr_wr = 1'b0, bit_wr = 1'b0, bit_val = 1'b0;
  logic [7:0] sfr_waddr = '0, sfr_wdata = '0, bit_addr = '0, sfr_raddr = '0;
  logic [7:0] sfr_rdata, irq_vec;
  logic       cpu_ack = 1'b0, cpu_reti = 1'b0, irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_arbiter8 u_dut (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .tmr2_req(tmr2_req), .ser_req(ser_req), .sfr_wr(sfr_wr), .sfr_waddr(sfr_waddr),
    .sfr_wdata(sfr_wdata), .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_val(bit_val),
    .sfr_raddr(sfr_raddr), .sfr_rdata(sfr_rdata), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
    .irq(irq), .irq_vec(irq_vec));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1'b1; sfr_waddr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic bw(input logic [7:0] a, input logic v);
    bit_wr = 1'b1; bit_addr = a; bit_val = v;
    @(negedge clk);
    bit_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_raddr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic ack();
    cpu_ack = 1'b1; @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic reti();
    cpu_reti = 1'b1; @(negedge clk); cpu_reti = 1'b0;
  endtask

  task automatic chk_irq(input logic e_irq, input int idx, input string tag);
    chk(irq === e_irq, {tag, " irq"}, int'(irq), int'(e_irq));
    if (e_irq) chk(irq_vec === 8'(idx * 8 + 3), {tag, " vec"}, int'(irq_vec), idx * 8 + 3);
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pms [8] = '{8'h00, 8'hFF, 8'h80, 8'h40, 8'h21, 8'h0C, 8'h55, 8'hAA};
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk_irq(1'b0, 0, "R1 reset");
    rd(8'h88, d); chk(d === 8'h00, "R1 ctl reset", d, 0);
    rd(8'hA8, d); chk(d === 8'h00, "R1 en reset", d, 0);
    rd(8'hB8, d); chk(d === 8'h00, "R1 lvl reset", d, 0);
    rd(8'hC0, d); chk(d === 8'h00, "R1 ext reset", d, 0);
    // R2 bit addressing
    bw(8'hC2, 1'b1);
    rd(8'hC0, d); chk(d === 8'h04, "R2 bit C2", d, 8'h04);
    bw(8'hC2, 1'b0);
    rd(8'hC0, d); chk(d === 8'h00, "R2 bit C2 clear", d, 0);
    // R1 unimplemented bits
    wr(8'hA8, 8'hFF); rd(8'hA8, d); chk(d === 8'hBF, "R1 en mask", d, 8'hBF);
    wr(8'hB8, 8'hFF); rd(8'hB8, d); chk(d === 8'h3F, "R1 lvl mask", d, 8'h3F);
    wr(8'hA8, 8'h00); wr(8'hB8, 8'h00);
    wr(8'h88, 8'hFF); rd(8'h88, d); chk(d === 8'hAF, "R1 ctl mask", d, 8'hAF);

    // R5 R6 per-source enables
    wr(8'h88, 8'hAF); ser_req = 1'b1; tmr2_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wr(8'hC0, 8'h33 | (i == 6 ? 8'h04 : 8'h00) | (i == 7 ? 8'h40 : 8'h00));
      wr(8'hA8, 8'h80 | (i < 6 ? 8'(1 << i) : 8'h00));
      chk_irq(1'b1, i, "R5 R6 single enable");
    end
    wr(8'hC0, 8'h77); wr(8'hA8, 8'h3F);
    chk_irq(1'b0, 0, "R5 global off");

    // R7 R6 sweep of pending and level patterns
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0] mm, pm, h, pool;
        int e;
        mm = 8'(m); pm = pms[p];
        ser_req = mm[4]; tmr2_req = mm[5];
        wr(8'h88, {mm[3], 1'b0, mm[1], 1'b0, mm[2], 1'b1, mm[0], 1'b1});
        wr(8'hC0, {pm[7], 1'b1, mm[7], 1'b1, pm[6], 1'b1, mm[6], 1'b1});
        wr(8'hB8, {2'b00, pm[5:0]});
        wr(8'hA8, 8'hBF);
        h = mm & pm; pool = (h != 0) ? h : mm; e = 0;
        for (int k = 7; k >= 0; k--) if (pool[k]) e = k;
        chk_irq(mm != 0, e, "R7 sweep");
      end
    end
    ser_req = 1'b0; tmr2_req = 1'b0;
    wr(8'h88, 8'h05); wr(8'hC0, 8'h11); wr(8'hB8, 8'h00); wr(8'hA8, 8'hBF);
    chk_irq(1'b0, 0, "R10 cleared");

    // R9 nesting
    bw(8'h89, 1'b1);
    chk_irq(1'b1, 0, "R10 sw raise");
    ack();
    chk_irq(1'b0, 0, "R9 low open");
    tmr0_ovf = 1'b1; tick(1); tmr0_ovf = 1'b0;
    rd(8'h88, d); chk(d[5] === 1'b1, "R11 tf0 set", d[5], 1);
    chk_irq(1'b0, 0, "R9 low blocks low");
    bw(8'hC7, 1'b1); bw(8'hC6, 1'b1);
    ext_n[3] = 1'b0; tick(3);
    chk_irq(1'b1, 7, "R9 high preempts R3");
    ack();
    chk_irq(1'b0, 0, "R9 high open");
    bw(8'hB9, 1'b1);
    chk_irq(1'b0, 0, "R9 high blocks high");
    reti();
    chk_irq(1'b1, 1, "R9 pop to low");
    ack();
    rd(8'h88, d); chk(d[5] === 1'b0, "R8 tf0 cleared", d[5], 0);
    chk_irq(1'b0, 0, "R9 high again");
    reti();
    chk_irq(1'b0, 0, "R9 low still open");
    reti();
    chk_irq(1'b0, 0, "R9 idle");
    ext_n[3] = 1'b1; tick(3);
    wr(8'hB8, 8'h00); wr(8'hC0, 8'h11);

    // R3 edge on pin 0
    ext_n[0] = 1'b0; tick(2);
    chk_irq(1'b0, 0, "R3 not yet");
    tick(1);
    chk_irq(1'b1, 0, "R3 third edge");
    ack();
    rd(8'h88, d); chk(d[1] === 1'b0, "R8 edge flag cleared", d[1], 0);
    reti(); tick(5);
    chk_irq(1'b0, 0, "R3 held low no retrigger");
    ext_n[0] = 1'b1; tick(3);
    chk_irq(1'b0, 0, "R3 release");

    // R4 level on pin 1
    bw(8'h8A, 1'b0);
    ext_n[1] = 1'b0; tick(2);
    chk_irq(1'b0, 0, "R4 not yet");
    tick(1);
    chk_irq(1'b1, 2, "R4 level");
    ack();
    rd(8'h88, d); chk(d[3] === 1'b1, "R4 R8 level kept", d[3], 1);
    chk_irq(1'b0, 0, "R9 level in service");
    reti();
    chk_irq(1'b1, 2, "R4 level again");
    ext_n[1] = 1'b1; tick(2);
    chk_irq(1'b1, 2, "R4 release delay");
    tick(1);
    chk_irq(1'b0, 0, "R4 released");

    // R8 ack ignored when idle, R10 software cancel
    ack();
    bw(8'h8D, 1'b1);
    chk_irq(1'b1, 1, "R8 idle ack ignored");
    bw(8'h8D, 1'b0);
    chk_irq(1'b0, 0, "R10 sw cancel");

    // R11 timer 1, R8 clear
    tmr1_ovf = 1'b1; tick(1); tmr1_ovf = 1'b0;
    chk_irq(1'b1, 3, "R11 tf1");
    ack();
    rd(8'h88, d); chk(d[7] === 1'b0, "R8 tf1 cleared", d[7], 0);
    reti();

    // R8 serial request untouched by ack
    ser_req = 1'b1; #1;
    chk_irq(1'b1, 4, "R8 serial");
    ack();
    chk_irq(1'b0, 0, "R8 serial in service");
    reti();
    chk_irq(1'b1, 4, "R8 serial kept");
    ser_req = 1'b0; #1;
    chk_irq(1'b0, 0, "R8 serial gone");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule